// File: doc/BRIEF.md
# Double-Buffer Circular DMA Channel

This block is one DMA channel that takes items from a peripheral through a request/acknowledge handshake and writes them to memory through a valid/ready write port. It fills one of two memory buffers at a time. When the programmed number of items has gone into the current buffer, the channel switches to the other buffer's base address, reloads its item counter and carries on. It never stops by itself. Software therefore works on one buffer while the hardware fills the other.

Each block that ends, or each stop in the middle of a block, raises a one-cycle completion pulse and sets a sticky completion flag. Other logic can watch the pulse to start a second-level transfer out of the finished buffer. A completion event that arrives while the flag is still set is recorded in an overrun flag. Software clears both flags by writing ones to a clear register.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset, `active`, `mem_valid`, `per_ack`, `tc_pulse`, `tc_flag`, `ovr_flag` and `cur_tgt` are 0.
- R2: Register writes use `cfg_addr` as follows. 0 is control, with bit 0 as the enable. 1 is the buffer-0 base. 2 is the buffer-1 base. 3 is the item count. 4 is the flag clear register. Writing 1 to the enable bit while idle starts the channel with `cur_tgt`=0, `mem_addr` at the buffer-0 base and `remaining` equal to the count. If the count is 0, the write is ignored and the channel stays idle.
- R3: The channel accepts an item only while `per_req` is high, no item is held, and `per_ack` is low. It acknowledges with a one-cycle `per_ack` in the next cycle. It presents the item on `mem_valid`/`mem_data`, and these stay stable until `mem_ready`.
- R4: Each item that is accepted by memory moves `mem_addr` forward by ITEM_BYTES and lowers `remaining` by one.
- R5: When the last item of a block is accepted, `cur_tgt` toggles and `mem_addr` moves to the base of the other buffer.
- R6: At the same point, `remaining` reloads to the programmed count and the channel stays active. While the channel is active, `remaining` is never 0.
- R7: Every block end produces a one-cycle `tc_pulse` in the next cycle and sets `tc_flag`.
- R8: Writing 0 to the enable bit while running stops intake. An item that is still held is first written out, and `active` stays high until then. The channel then goes idle. If the block was partly done at that point, it raises `tc_pulse`/`tc_flag`. A stop exactly at a block boundary raises nothing.
- R9: Writing a value with bit 0 = 1 to the clear register clears `tc_flag`. Writing 0 there has no effect. If a completion happens in the same cycle, the set wins.
- R10: A completion that arrives while `tc_flag` is already set, and is not being cleared in that cycle, sets `ovr_flag`. Writing bit 1 = 1 to the clear register clears `ovr_flag`.
- R11: A count write while the channel is active is ignored. A base write takes effect the next time that buffer is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| per_req | input | 1 | Peripheral has an item |
| per_data | input | DATA_W | Peripheral item |
| per_ack | output | 1 | Item taken (one-cycle pulse) |
| mem_valid | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | DATA_W | Memory write data |
| tc_pulse | output | 1 | Completion event pulse |
| tc_flag | output | 1 | Sticky completion flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| active | output | 1 | Channel running or draining |
| cur_tgt | output | 1 | Buffer being filled |
| remaining | output | CNT_W | Items left in the current block |

## Verification
The assertions check the properties that hold on every cycle. These are the single-cycle acknowledge, the stability of a stalled memory write, that a buffer toggle during running always comes with a completion pulse, that `remaining` is nonzero while active, that a pulse always leaves the flag set, that overrun only rises over a set flag, and that there is no memory traffic while idle. The exact addresses after a swap, the reload value and the effect of base writes made mid-run need the bench's scenarios. So do the handling of ignored count writes, the drain-then-stop sequence, and whether a stop raises completion at a block boundary or in mid-block. In those scenarios the reference model is compared against every output on every clock.

// File: rtl/dbuf_pkg.sv
// Package: shared state encoding and register select values for the
// double-buffer DMA channel. Assumes a 3-bit register select.
package dbuf_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_DRAIN = 2'd2
    } ch_state_t;

    localparam int SEL_W     = 3;
    localparam int CFG_W     = 32;
    localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_BASE0 = 3'd1;
    localparam logic [SEL_W-1:0] SEL_BASE1 = 3'd2;
    localparam logic [SEL_W-1:0] SEL_COUNT = 3'd3;
    localparam logic [SEL_W-1:0] SEL_CLEAR = 3'd4;

    localparam int CLR_TC_BIT  = 0;
    localparam int CLR_OVR_BIT = 1;
    localparam int EN_BIT      = 0;

endpackage

// File: rtl/dbuf_regs.sv
// Module: configuration registers. Holds both buffer bases and the block
// count, and decodes control and clear writes into one-cycle commands.
// Assumes ADDR_W and CNT_W are no wider than the write data.
module dbuf_regs
    import dbuf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              chan_idle,
    output logic [ADDR_W-1:0] base0,
    output logic [ADDR_W-1:0] base1,
    output logic [CNT_W-1:0]  reload,
    output logic              start_req,
    output logic              stop_req,
    output logic              clr_tc,
    output logic              clr_ovr
);

    logic wr_ctrl, wr_clear;

    // Decode write strobes per register.
    always_comb begin
        wr_ctrl   = cfg_we && (cfg_addr == SEL_CTRL);
        wr_clear  = cfg_we && (cfg_addr == SEL_CLEAR);
        start_req = wr_ctrl && cfg_wdata[EN_BIT] && chan_idle
                    && (reload != '0);
        stop_req  = wr_ctrl && !cfg_wdata[EN_BIT] && !chan_idle;
        clr_tc    = wr_clear && cfg_wdata[CLR_TC_BIT];
        clr_ovr   = wr_clear && cfg_wdata[CLR_OVR_BIT];
    end

    // Store bases at any time; the count only while the channel is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base0  <= '0;
            base1  <= '0;
            reload <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == SEL_BASE0) base0 <= cfg_wdata[ADDR_W-1:0];
            if (cfg_addr == SEL_BASE1) base1 <= cfg_wdata[ADDR_W-1:0];
            if (cfg_addr == SEL_COUNT && chan_idle)
                reload <= cfg_wdata[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/dbuf_xfer.sv
// Module: transfer engine. Takes one peripheral item at a time into a
// holding register, writes it to memory, steps address and count, and
// swaps buffers with an automatic count reload at each terminal count.
// Stops on request after draining any held item. Assumes the peripheral
// may keep per_req high; the ack gap prevents double takes.
module dbuf_xfer
    import dbuf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 16,
    parameter int ITEM_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base0,
    input  logic [ADDR_W-1:0] base1,
    input  logic [CNT_W-1:0]  reload,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              per_req,
    input  logic [DATA_W-1:0] per_data,
    output logic              per_ack,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              chan_idle,
    output logic              cur_tgt,
    output logic [CNT_W-1:0]  remaining,
    output logic              tc_evt
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ITEM_BYTES);
    localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

    ch_state_t         st, st_nxt;
    logic              hold_v, ack_q, tgt;
    logic [DATA_W-1:0] hold_d;
    logic [CNT_W-1:0]  cnt, cnt_adv;
    logic [ADDR_W-1:0] addr, addr_adv;
    logic              tgt_adv;
    logic              beat_done, last_beat, take, halting;

    // Handshake qualifiers for this cycle.
    always_comb begin
        beat_done = hold_v && mem_ready;
        last_beat = beat_done && (cnt == ONE);
        take      = (st == CH_RUN) && !stop_req && per_req && !hold_v && !ack_q;
    end

    // Position after a completed beat, including the buffer swap.
    always_comb begin
        cnt_adv  = cnt;
        addr_adv = addr;
        tgt_adv  = tgt;
        if (last_beat) begin
            cnt_adv  = reload;
            tgt_adv  = !tgt;
            addr_adv = tgt ? base0 : base1;
        end else if (beat_done) begin
            cnt_adv  = cnt - ONE;
            addr_adv = addr + STEP;
        end
    end

    // Channel state sequencing and stop detection.
    always_comb begin
        st_nxt  = st;
        halting = 1'b0;
        case (st)
            CH_IDLE:  if (start_req) st_nxt = CH_RUN;
            CH_RUN: begin
                if (stop_req) begin
                    if (hold_v && !beat_done) begin
                        st_nxt = CH_DRAIN;
                    end else begin
                        st_nxt  = CH_IDLE;
                        halting = 1'b1;
                    end
                end
            end
            CH_DRAIN: begin
                if (beat_done) begin
                    st_nxt  = CH_IDLE;
                    halting = 1'b1;
                end
            end
            default:  st_nxt = CH_IDLE;
        endcase
        tc_evt = last_beat || (halting && (cnt_adv != reload));
    end

    // State, holding register and position registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= CH_IDLE;
            ack_q  <= 1'b0;
            hold_v <= 1'b0;
            hold_d <= '0;
            cnt    <= '0;
            addr   <= '0;
            tgt    <= 1'b0;
        end else begin
            st    <= st_nxt;
            ack_q <= take;
            if (take) begin
                hold_v <= 1'b1;
                hold_d <= per_data;
            end else if (beat_done) begin
                hold_v <= 1'b0;
            end
            if (start_req && st == CH_IDLE) begin
                cnt  <= reload;
                addr <= base0;
                tgt  <= 1'b0;
            end else if (beat_done) begin
                cnt  <= cnt_adv;
                addr <= addr_adv;
                tgt  <= tgt_adv;
            end
        end
    end

    // Port mapping of internal state.
    always_comb begin
        per_ack   = ack_q;
        mem_valid = hold_v;
        mem_addr  = addr;
        mem_data  = hold_d;
        chan_idle = (st == CH_IDLE);
        cur_tgt   = tgt;
        remaining = cnt;
    end

endmodule

// File: rtl/dbuf_flags.sv
// Module: sticky completion and overrun flags plus the completion pulse.
// A completion set wins over a same-cycle clear. OVR_EN=0 ties overrun low.
module dbuf_flags #(
    parameter bit OVR_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tc_evt,
    input  logic clr_tc,
    input  logic clr_ovr,
    output logic tc_pulse,
    output logic tc_flag,
    output logic ovr_flag
);

    // Completion flag and registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_flag  <= 1'b0;
            tc_pulse <= 1'b0;
        end else begin
            tc_pulse <= tc_evt;
            if (tc_evt)      tc_flag <= 1'b1;
            else if (clr_tc) tc_flag <= 1'b0;
        end
    end

    generate
        if (OVR_EN) begin : g_ovr
            logic ovr_q;
            // Overrun: event lands on a flag that is set and not being cleared.
            always_ff @(posedge clk) begin
                if (!rst_n)                          ovr_q <= 1'b0;
                else if (tc_evt && tc_flag && !clr_tc) ovr_q <= 1'b1;
                else if (clr_ovr)                    ovr_q <= 1'b0;
            end
            assign ovr_flag = ovr_q;
        end else begin : g_no_ovr
            assign ovr_flag = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/dbuf_dma_chan.sv
// Module: top of the double-buffer circular DMA channel. Connects the
// register file, transfer engine and flag logic. Assumes one outstanding
// memory write and a peripheral that holds per_req until acknowledged.
module dbuf_dma_chan
    import dbuf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 16,
    parameter int ITEM_BYTES = 4,
    parameter bit OVR_EN     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              per_req,
    input  logic [DATA_W-1:0] per_data,
    output logic              per_ack,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              tc_pulse,
    output logic              tc_flag,
    output logic              ovr_flag,
    output logic              active,
    output logic              cur_tgt,
    output logic [CNT_W-1:0]  remaining
);

    logic [ADDR_W-1:0] base0, base1;
    logic [CNT_W-1:0]  reload;
    logic start_req, stop_req, clr_tc, clr_ovr, chan_idle, tc_evt;

    dbuf_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .chan_idle(chan_idle), .base0(base0),
        .base1(base1), .reload(reload), .start_req(start_req),
        .stop_req(stop_req), .clr_tc(clr_tc), .clr_ovr(clr_ovr)
    );

    dbuf_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
                .ITEM_BYTES(ITEM_BYTES)) u_xfer (
        .clk(clk), .rst_n(rst_n), .base0(base0), .base1(base1),
        .reload(reload), .start_req(start_req), .stop_req(stop_req),
        .per_req(per_req), .per_data(per_data), .per_ack(per_ack),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .chan_idle(chan_idle), .cur_tgt(cur_tgt),
        .remaining(remaining), .tc_evt(tc_evt)
    );

    dbuf_flags #(.OVR_EN(OVR_EN)) u_flags (
        .clk(clk), .rst_n(rst_n), .tc_evt(tc_evt), .clr_tc(clr_tc),
        .clr_ovr(clr_ovr), .tc_pulse(tc_pulse), .tc_flag(tc_flag),
        .ovr_flag(ovr_flag)
    );

    // Channel is busy whenever it is not idle.
    always_comb active = !chan_idle;

endmodule

// File: rtl/dbuf_dma_chan_chk.sv
// Module: property checker for the channel's ports, bound to the top.
module dbuf_dma_chan_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              per_ack,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic              tc_pulse,
    input logic              tc_flag,
    input logic              ovr_flag,
    input logic              active,
    input logic              cur_tgt,
    input logic [CNT_W-1:0]  remaining
);

    assert_ack_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |=> !per_ack);

    assert_write_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    assert_swap_signalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !$stable(cur_tgt)) |-> tc_pulse);

    assert_count_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (remaining != '0));

    assert_pulse_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> tc_flag);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mem_valid);

    assert_ovr_over_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> tc_flag);

endmodule

bind dbuf_dma_chan dbuf_dma_chan_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .per_ack(per_ack), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .tc_pulse(tc_pulse), .tc_flag(tc_flag), .ovr_flag(ovr_flag),
    .active(active), .cur_tgt(cur_tgt), .remaining(remaining)
);

// File: tb/dbuf_dma_chan_bench.sv
module dbuf_dma_chan_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        per_req = 1'b0;
    logic [31:0] per_data = 32'hA000_0001;
    logic        mem_ready = 1'b0;
    logic        per_ack, mem_valid, tc_pulse, tc_flag, ovr_flag, active, cur_tgt;
    logic [31:0] mem_addr, mem_data;
    logic [15:0] remaining;

    int checks = 0;
    int fails  = 0;
    int pend   = 0;
    int rmode  = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit cmp_en = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbuf_dma_chan u_dbuf_dma_chan (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .per_req(per_req), .per_data(per_data),
        .per_ack(per_ack), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .tc_pulse(tc_pulse),
        .tc_flag(tc_flag), .ovr_flag(ovr_flag), .active(active),
        .cur_tgt(cur_tgt), .remaining(remaining)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Reference model: channel behaviour from the requirements, per clock.
    int m_state = 0;
    logic [31:0] m_b0 = 0, m_b1 = 0, m_addr = 0, m_hd = 0;
    int m_reload = 0, m_cnt = 0;
    bit m_tgt = 0, m_hv = 0, m_ack = 0, m_tcf = 0, m_ovf = 0, m_tcp = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_b0 = 0; m_b1 = 0; m_addr = 0; m_hd = 0;
            m_reload = 0; m_cnt = 0; m_tgt = 0; m_hv = 0; m_ack = 0;
            m_tcf = 0; m_ovf = 0; m_tcp = 0;
        end else begin
            bit wctl, start, stop, done, take, evt, halt, ctc, covr;
            int ncnt, nstate;
            logic [31:0] naddr;
            bit ntgt;
            wctl  = cfg_we && cfg_addr == 3'd0;
            start = wctl && cfg_wdata[0] && m_state == 0 && m_reload != 0;
            stop  = wctl && !cfg_wdata[0] && m_state == 1;
            ctc   = cfg_we && cfg_addr == 3'd4 && cfg_wdata[0];
            covr  = cfg_we && cfg_addr == 3'd4 && cfg_wdata[1];
            done  = m_hv && mem_ready;
            take  = m_state == 1 && !stop && per_req && !m_hv && !m_ack;
            evt = 0; halt = 0; ncnt = m_cnt; naddr = m_addr; ntgt = m_tgt;
            if (done) begin
                if (m_cnt == 1) begin
                    evt = 1; ntgt = !m_tgt; ncnt = m_reload;
                    naddr = m_tgt ? m_b0 : m_b1;
                end else begin
                    ncnt = m_cnt - 1; naddr = m_addr + 4;
                end
            end
            nstate = m_state;
            if (m_state == 0 && start) nstate = 1;
            else if (m_state == 1 && stop) begin
                if (m_hv && !done) nstate = 2;
                else begin nstate = 0; halt = 1; end
            end else if (m_state == 2 && done) begin
                nstate = 0; halt = 1;
            end
            if (halt && ncnt != m_reload) evt = 1;
            if (start) begin ncnt = m_reload; naddr = m_b0; ntgt = 0; end
            if (evt && m_tcf && !ctc) m_ovf = 1; else if (covr) m_ovf = 0;
            if (evt) m_tcf = 1; else if (ctc) m_tcf = 0;
            m_tcp = evt;
            if (take) begin m_hv = 1; m_hd = per_data; end else if (done) m_hv = 0;
            m_ack = take;
            if (cfg_we && cfg_addr == 3'd3 && m_state == 0) m_reload = int'(cfg_wdata[15:0]);
            if (cfg_we && cfg_addr == 3'd1) m_b0 = cfg_wdata;
            if (cfg_we && cfg_addr == 3'd2) m_b1 = cfg_wdata;
            m_state = nstate; m_cnt = ncnt; m_addr = naddr; m_tgt = ntgt;
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(per_ack == m_ack, "R3 per_ack", 32'(per_ack), 32'(m_ack));
            chk(mem_valid == m_hv, "R3 mem_valid", 32'(mem_valid), 32'(m_hv));
            chk(mem_data == m_hd, "R3 mem_data", mem_data, m_hd);
            chk(mem_addr == m_addr, "R4 mem_addr", mem_addr, m_addr);
            chk(int'(remaining) == m_cnt, "R6 remaining", 32'(remaining), 32'(m_cnt));
            chk(cur_tgt == m_tgt, "R5 cur_tgt", 32'(cur_tgt), 32'(m_tgt));
            chk(active == (m_state != 0), "R8 active", 32'(active), 32'(m_state != 0));
            chk(tc_pulse == m_tcp, "R7 tc_pulse", 32'(tc_pulse), 32'(m_tcp));
            chk(tc_flag == m_tcf, "R9 tc_flag", 32'(tc_flag), 32'(m_tcf));
            chk(ovr_flag == m_ovf, "R10 ovr_flag", 32'(ovr_flag), 32'(m_ovf));
        end
    end

    // Peripheral and memory stimulus: feeds pending items, drives ready.
    always @(negedge clk) begin
        if (per_ack) begin
            pend--;
            per_data = per_data + 32'h0101_0011;
        end
        per_req = (pend > 0);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready = (rmode == 1) ? 1'b1 : (rmode == 2) ? 1'b0 : lfsr[0];
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic feed(input int n);
        pend = pend + n;
        @(negedge clk);
        while (pend != 0 || mem_valid || per_ack) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scenario;
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        cmp_en = 1;
        // R1: reset state
        chk(!active && !mem_valid && !per_ack, "R1 idle outputs", {active, mem_valid, per_ack}, 0);
        chk(!tc_flag && !ovr_flag && !tc_pulse && !cur_tgt, "R1 flags", {tc_flag, ovr_flag, tc_pulse, cur_tgt}, 0);
        // R2: enabling with zero count is ignored
        wr(3'd0, 32'd1);
        idle(2);
        chk(!active, "R2 zero count enable ignored", 32'(active), 0);
        wr(3'd1, 32'h1000);
        wr(3'd2, 32'h2000);
        wr(3'd3, 32'd3);
        rmode = 0;
        wr(3'd0, 32'd1);
        chk(active && mem_addr == 32'h1000 && remaining == 3, "R2 start point", mem_addr, 32'h1000);
        // Two block ends and one item into the third block (R5, R6, R7)
        feed(7);
        chk(tc_flag && ovr_flag, "R10 overrun after second completion", {tc_flag, ovr_flag}, 3);
        chk(mem_addr == 32'h1004 && !cur_tgt, "R5 back in buffer 0", mem_addr, 32'h1004);
        // R9: clear behaviour
        wr(3'd4, 32'd0);
        chk(tc_flag, "R9 zero write keeps flag", 32'(tc_flag), 1);
        wr(3'd4, 32'd1);
        chk(!tc_flag && ovr_flag, "R9 clear tc only", {tc_flag, ovr_flag}, 1);
        wr(3'd4, 32'd2);
        chk(!ovr_flag, "R10 overrun cleared", 32'(ovr_flag), 0);
        // R11: count write ignored while active, base write used at next entry
        wr(3'd3, 32'd5);
        wr(3'd2, 32'h4000);
        feed(2);
        chk(remaining == 3, "R11 count kept at 3", 32'(remaining), 3);
        chk(mem_addr == 32'h4000 && cur_tgt, "R11 new buffer-1 base", mem_addr, 32'h4000);
        // R8: stop mid-block raises completion
        wr(3'd4, 32'd3);
        feed(1);
        wr(3'd0, 32'd0);
        chk(!active && tc_flag && tc_pulse, "R8 mid-block stop", {active, tc_flag, tc_pulse}, 3'b011);
        // R8: stop with a held item drains first
        wr(3'd4, 32'd3);
        rmode = 2;
        wr(3'd0, 32'd1);
        pend = pend + 1;
        while (!mem_valid) @(negedge clk);
        wr(3'd0, 32'd0);
        chk(active && mem_valid, "R8 draining keeps active", {active, mem_valid}, 3);
        idle(3);
        chk(active, "R8 still draining while stalled", 32'(active), 1);
        rmode = 1;
        idle(3);
        chk(!active && tc_flag, "R8 drained then stopped", {active, tc_flag}, 1);
        // R8: stop exactly at a block boundary raises nothing
        wr(3'd0, 32'd1);
        feed(3);
        wr(3'd4, 32'd3);
        wr(3'd0, 32'd0);
        idle(1);
        chk(!active && !tc_flag, "R8 boundary stop silent", {active, tc_flag}, 0);
        // Long random run across many swaps
        wr(3'd3, 32'd4);
        rmode = 0;
        wr(3'd0, 32'd1);
        feed(21);
        chk(active && remaining == 3, "R6 still running after many blocks", 32'(remaining), 3);
        wr(3'd0, 32'd0);
        idle(4);
    endtask

    initial begin
        fork
            scenario();
            begin
                repeat (WATCHDOG) @(posedge clk);
                fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule